// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block drains data from a controller's sector buffer, either to a CPU that fetches it word by word or to a memory destination served by DMA. A byte counter and a buffer address counter are loaded one byte lane at a time through a small register port. A trigger command then starts a transfer. The kind of transfer depends on a 3-bit destination code. In host mode every accepted read strobe from the CPU named by the code returns one 16-bit word from the buffer and steps both counters. In DMA mode the memory-side copy is not modelled: a timer that stands in for it runs for a time proportional to the byte count and then produces a done pulse.

The byte counter holds the transfer length minus one. Reads bring it down by two. The end of a transfer has two stages. When the count left after a read is positive but at most two, an active-low transfer-end interrupt flag is set and the interrupt line rises if it is enabled. When the count drops to zero or below, the engine goes idle and the counter reloads to all ones. An acknowledge command clears the pending end flag. A control write with output enable cleared aborts a running transfer.

Top module: `hdx_engine`

## Requirements
- R1: After reset, xfer_idle, data_avail_n and end_pend_n are 1, host_ready, host_end, irq and dma_done are 0, and both counters are 0.
- R2: A trigger command (cfg_sel 5) is ignored when output enable (control bit 0) is clear. With output enable set and a destination code other than 2, 3, 4, 5 or 7, the trigger clears xfer_idle but leaves data_avail_n high and never produces dma_done.
- R3: A trigger with code 2 (main CPU) or 3 (sub CPU) clears xfer_idle, host_end and data_avail_n, sets host_ready, and clears byte_count bits 15:12.
- R4: A host read loads host_rdata one cycle later with the buffer word at buf_addr, which is addr_count bits 13:1 with bit 0 forced to 0. Only a read from the matching CPU (host_is_sub=0 for code 2, host_is_sub=1 for code 3) adds 2 to addr_count and subtracts 2 from byte_count. A read from the other CPU leaves both counters unchanged.
- R5: When the count after a matching read is zero or negative as a signed 16-bit value, byte_count becomes 0xFFFF, xfer_idle and data_avail_n go to 1, host_ready goes to 0 and host_end goes to 1.
- R6: When the count after a matching read lies between 1 and 2, end_pend_n goes low, irq rises if end-interrupt enable (control bit 1) is set, and host_ready and host_end are both 1.
- R7: A host read while data_avail_n is 1 returns 0xFFFF and changes no counter.
- R8: An acknowledge command (cfg_sel 6) sets end_pend_n, clears byte_count bits 15:12, and clears irq unless dec_irq_pend is 1.
- R9: A control write (cfg_sel 0) with bit 0 clear sets xfer_idle and data_avail_n and cancels a running DMA.
- R10: A trigger with code 4, 5 or 7 gives a one-cycle dma_done pulse 4×(byte_count[11:0])+1 cycles after the trigger edge. At the same edge addr_count advances by byte_count+1, byte_count reloads to 0xFFFF, xfer_idle and data_avail_n and host_end go high, end_pend_n goes low, and irq rises if it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | 0 control, 1/2 count low/high, 3/4 address low/high, 5 trigger, 6 acknowledge |
| cfg_wdata | input | 8 | Register write data |
| dest_code | input | 3 | Transfer destination code |
| dec_irq_pend | input | 1 | A decoder interrupt is pending elsewhere |
| host_rd | input | 1 | Host word read strobe |
| host_is_sub | input | 1 | Read issued by the sub CPU (0 = main CPU) |
| host_rdata | output | 16 | Word returned to the host |
| buf_addr | output | 14 | Buffer RAM word-aligned read address |
| buf_rdata | input | 16 | Buffer RAM read data (combinational) |
| xfer_idle | output | 1 | High when no transfer is in progress |
| data_avail_n | output | 1 | Low while host data can be read |
| end_pend_n | output | 1 | Low while a transfer-end interrupt is pending |
| host_ready | output | 1 | Host data-ready flag |
| host_end | output | 1 | Host end-of-transfer flag |
| irq | output | 1 | Transfer-end interrupt request |
| dma_done | output | 1 | One-cycle pulse when a DMA transfer finishes |
| byte_count | output | 16 | Byte counter |
| addr_count | output | 16 | Buffer address counter |

## Verification
The assertions assume that a register write and a host read never fall in the same cycle. They also assume that the destination code does not change while a transfer is running, and that the buffer RAM returns data combinationally. The stimulus drives every strobe for exactly one clock, changes inputs only on the falling edge, and never overlaps a write with a read. The destination code is set before each trigger and held until the next one.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL   = 3'd0,
      SEL_CNT_LO = 3'd1,
      SEL_CNT_HI = 3'd2,
      SEL_ADR_LO = 3'd3,
      SEL_ADR_HI = 3'd4,
      SEL_TRIG   = 3'd5,
      SEL_ACK    = 3'd6
   } sel_e;

   localparam logic [2:0] DST_MAIN = 3'd2;
   localparam logic [2:0] DST_SUB  = 3'd3;
   localparam logic [2:0] DST_PCM  = 3'd4;
   localparam logic [2:0] DST_PRG  = 3'd5;
   localparam logic [2:0] DST_WORD = 3'd7;

   typedef enum logic [1:0] {KIND_NONE, KIND_HOST, KIND_DMA} kind_e;

   function automatic kind_e classify(input logic [2:0] d);
      case (d)
         DST_MAIN, DST_SUB:          return KIND_HOST;
         DST_PCM, DST_PRG, DST_WORD: return KIND_DMA;
         default:                    return KIND_NONE;
      endcase
   endfunction
endpackage

// File: rtl/hdx_counters.sv
module hdx_counters #(
   parameter int CNT_W  = 16,
   parameter int LIVE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cnt_lo,
   input  logic             wr_cnt_hi,
   input  logic             wr_adr_lo,
   input  logic             wr_adr_hi,
   input  logic [7:0]       wdata,
   input  logic             clip,
   input  logic             step,
   input  logic             reload,
   input  logic             dma_fin,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] adr,
   output logic             le0,
   output logic             le2
);
   localparam logic [CNT_W-1:0] LIVE_MASK = CNT_W'((64'd1 << LIVE_W) - 64'd1);
   localparam logic [CNT_W-9:0] HI_MASK   = LIVE_MASK[CNT_W-1:8];

   logic [CNT_W-1:0] step_v;
   assign step_v = cnt - CNT_W'(2);
   assign le0    = $signed(step_v) <= 0;
   assign le2    = $signed(step_v) <= 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (wr_cnt_lo) begin
         cnt[7:0] <= wdata;
      end else if (wr_cnt_hi) begin
         cnt[CNT_W-1:8] <= wdata[CNT_W-9:0] & HI_MASK;
      end else if (clip) begin
         cnt <= cnt & LIVE_MASK;
      end else if (reload) begin
         cnt <= '1;
      end else if (step) begin
         cnt <= step_v;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr <= '0;
      end else if (wr_adr_lo) begin
         adr[7:0] <= wdata;
      end else if (wr_adr_hi) begin
         adr[CNT_W-1:8] <= wdata[CNT_W-9:0];
      end else if (step) begin
         adr <= adr + CNT_W'(2);
      end else if (dma_fin) begin
         adr <= adr + cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/hdx_dma_timer.sv
module hdx_dma_timer #(
   parameter int LIVE_W       = 12,
   parameter int CYC_PER_BYTE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cancel,
   input  logic [LIVE_W-1:0] len,
   output logic              expire,
   output logic              busy,
   output logic              done
);
   localparam int SHIFT = $clog2(CYC_PER_BYTE);
   localparam int TW    = LIVE_W + SHIFT + 1;

   logic [TW-1:0] load_val;
   logic [TW-1:0] left;

   generate
      if ((CYC_PER_BYTE & (CYC_PER_BYTE - 1)) == 0) begin : g_shift
         assign load_val = TW'(len) << SHIFT;
      end else begin : g_mul
         assign load_val = TW'(len) * TW'(CYC_PER_BYTE);
      end
   endgenerate

   assign expire = busy && (left == '0) && !start && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
         done <= 1'b0;
      end else begin
         done <= expire;
         if (cancel) begin
            busy <= 1'b0;
         end else if (start) begin
            busy <= 1'b1;
            left <= load_val;
         end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - TW'(1);
         end
      end
   end
endmodule

// File: rtl/hdx_status.sv
module hdx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_ok,
   input  logic trig_host,
   input  logic host_adv,
   input  logic le0,
   input  logic le2,
   input  logic expire,
   input  logic ack,
   input  logic abort,
   input  logic ctrl_wr,
   input  logic irq_en_new,
   input  logic irq_en,
   input  logic dec_pend,
   output logic idle,
   output logic unav,
   output logic endp_n,
   output logic ready,
   output logic hend,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle   <= 1'b1;
         unav   <= 1'b1;
         endp_n <= 1'b1;
         ready  <= 1'b0;
         hend   <= 1'b0;
         irq    <= 1'b0;
      end else begin
         if (abort) begin
            idle <= 1'b1;
            unav <= 1'b1;
         end
         if (ctrl_wr) irq <= irq_en_new && !endp_n;
         if (trig_ok) begin
            idle  <= 1'b0;
            hend  <= 1'b0;
            unav  <= !trig_host;
            ready <= trig_host;
         end
         if (host_adv) begin
            if (le0) begin
               idle  <= 1'b1;
               unav  <= 1'b1;
               ready <= 1'b0;
               hend  <= 1'b1;
            end else if (le2) begin
               ready <= 1'b1;
               hend  <= 1'b1;
               if (endp_n) begin
                  endp_n <= 1'b0;
                  if (irq_en) irq <= 1'b1;
               end
            end
         end
         if (expire) begin
            idle  <= 1'b1;
            unav  <= 1'b1;
            ready <= 1'b0;
            hend  <= 1'b1;
            if (endp_n) begin
               endp_n <= 1'b0;
               if (irq_en) irq <= 1'b1;
            end
         end
         if (ack) begin
            endp_n <= 1'b1;
            if (!dec_pend) irq <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hdx_engine.sv
module hdx_engine #(
   parameter int CNT_W        = 16,
   parameter int LIVE_W       = 12,
   parameter int BUF_AW       = 14,
   parameter int CYC_PER_BYTE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic [2:0]        dest_code,
   input  logic              dec_irq_pend,
   input  logic              host_rd,
   input  logic              host_is_sub,
   output logic [15:0]       host_rdata,
   output logic [BUF_AW-1:0] buf_addr,
   input  logic [15:0]       buf_rdata,
   output logic              xfer_idle,
   output logic              data_avail_n,
   output logic              end_pend_n,
   output logic              host_ready,
   output logic              host_end,
   output logic              irq,
   output logic              dma_done,
   output logic [CNT_W-1:0]  byte_count,
   output logic [CNT_W-1:0]  addr_count
);
   import hdx_pkg::*;

   generate
      if (CNT_W != 16) begin : g_bad_cnt
         $error("hdx_engine: CNT_W must be 16 (two byte lanes)");
      end
      if (LIVE_W < 8 || LIVE_W >= CNT_W) begin : g_bad_live
         $error("hdx_engine: LIVE_W must lie in [8, CNT_W)");
      end
      if (BUF_AW < 2 || BUF_AW > CNT_W) begin : g_bad_aw
         $error("hdx_engine: BUF_AW out of range");
      end
      if (CYC_PER_BYTE < 1) begin : g_bad_cyc
         $error("hdx_engine: CYC_PER_BYTE must be positive");
      end
   endgenerate

   logic [7:0] ctrl_q;
   logic       out_en, irq_en;
   assign out_en = ctrl_q[0];
   assign irq_en = ctrl_q[1];

   logic wr_ctrl, wr_trig, wr_ack;
   assign wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
   assign wr_trig = cfg_wr && (cfg_sel == SEL_TRIG);
   assign wr_ack  = cfg_wr && (cfg_sel == SEL_ACK);

   kind_e kind;
   assign kind = classify(dest_code);

   logic trig_ok, abort, match, host_adv, le0, le2, expire, dma_busy;
   assign trig_ok = wr_trig && out_en;
   assign abort   = wr_ctrl && !cfg_wdata[0];
   assign match   = host_is_sub ? (dest_code == DST_SUB) : (dest_code == DST_MAIN);
   assign host_adv = host_rd && !cfg_wr && !data_avail_n && match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= cfg_wdata;
   end

   hdx_counters #(.CNT_W(CNT_W), .LIVE_W(LIVE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .wr_cnt_lo(cfg_wr && (cfg_sel == SEL_CNT_LO)),
      .wr_cnt_hi(cfg_wr && (cfg_sel == SEL_CNT_HI)),
      .wr_adr_lo(cfg_wr && (cfg_sel == SEL_ADR_LO)),
      .wr_adr_hi(cfg_wr && (cfg_sel == SEL_ADR_HI)),
      .wdata(cfg_wdata),
      .clip(trig_ok || wr_ack),
      .step(host_adv),
      .reload((host_adv && le0) || expire),
      .dma_fin(expire),
      .cnt(byte_count), .adr(addr_count),
      .le0(le0), .le2(le2)
   );

   hdx_dma_timer #(.LIVE_W(LIVE_W), .CYC_PER_BYTE(CYC_PER_BYTE)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .start(trig_ok && (kind == KIND_DMA)),
      .cancel(abort || (trig_ok && (kind != KIND_DMA))),
      .len(byte_count[LIVE_W-1:0]),
      .expire(expire), .busy(dma_busy), .done(dma_done)
   );

   hdx_status u_st (
      .clk(clk), .rst_n(rst_n),
      .trig_ok(trig_ok), .trig_host(kind == KIND_HOST),
      .host_adv(host_adv), .le0(le0), .le2(le2),
      .expire(expire), .ack(wr_ack), .abort(abort),
      .ctrl_wr(wr_ctrl), .irq_en_new(cfg_wdata[1]), .irq_en(irq_en),
      .dec_pend(dec_irq_pend),
      .idle(xfer_idle), .unav(data_avail_n), .endp_n(end_pend_n),
      .ready(host_ready), .hend(host_end), .irq(irq)
   );

   assign buf_addr = {addr_count[BUF_AW-1:1], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       host_rdata <= '1;
      else if (host_rd) host_rdata <= data_avail_n ? 16'hFFFF : buf_rdata;
   end
endmodule

// File: rtl/hdx_engine_chk.sv
module hdx_engine_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [2:0]       cfg_sel,
   input logic [7:0]       cfg_wdata,
   input logic [2:0]       dest_code,
   input logic             host_rd,
   input logic             host_is_sub,
   input logic [15:0]      host_rdata,
   input logic             xfer_idle,
   input logic             data_avail_n,
   input logic             end_pend_n,
   input logic             dma_done,
   input logic [CNT_W-1:0] byte_count,
   input logic [CNT_W-1:0] addr_count,
   input logic             out_en
);
   // R10
   done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |-> (xfer_idle && data_avail_n && byte_count == '1));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> !dma_done);
   // R7
   unavail_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && data_avail_n) |=> (host_rdata == 16'hFFFF));
   // R4
   foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !cfg_wr && !data_avail_n &&
       !(host_is_sub ? (dest_code == 3'd3) : (dest_code == 3'd2)))
      |=> ($stable(byte_count) && $stable(addr_count)));
   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 3'd0 && !cfg_wdata[0]) |=> (xfer_idle && data_avail_n));
   // R8
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 3'd6) |=> (end_pend_n && byte_count[CNT_W-1:12] == '0));
   // R2
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 3'd5 && !out_en) |=> ($stable(xfer_idle) && $stable(data_avail_n)));
endmodule

bind hdx_engine hdx_engine_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
   .cfg_wdata(cfg_wdata), .dest_code(dest_code), .host_rd(host_rd),
   .host_is_sub(host_is_sub), .host_rdata(host_rdata), .xfer_idle(xfer_idle),
   .data_avail_n(data_avail_n), .end_pend_n(end_pend_n), .dma_done(dma_done),
   .byte_count(byte_count), .addr_count(addr_count), .out_en(ctrl_q[0])
);

// File: tb/tb_hdx_engine.sv
`timescale 1ns/1ps
module tb_hdx_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [7:0]  cfg_wdata = 8'd0;
   logic [2:0]  dest_code = 3'd0;
   logic        dec_irq_pend = 1'b0;
   logic        host_rd = 1'b0;
   logic        host_is_sub = 1'b0;
   logic [15:0] host_rdata;
   logic [13:0] buf_addr;
   logic [15:0] buf_rdata;
   logic        xfer_idle, data_avail_n, end_pend_n, host_ready, host_end, irq, dma_done;
   logic [15:0] byte_count, addr_count;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] ram_word(input logic [13:0] a);
      return {a[7:0] ^ 8'hA5, a[13:6]};
   endfunction
   assign buf_rdata = ram_word(buf_addr);

   hdx_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dest_code(dest_code), .dec_irq_pend(dec_irq_pend),
      .host_rd(host_rd), .host_is_sub(host_is_sub), .host_rdata(host_rdata),
      .buf_addr(buf_addr), .buf_rdata(buf_rdata), .xfer_idle(xfer_idle),
      .data_avail_n(data_avail_n), .end_pend_n(end_pend_n), .host_ready(host_ready),
      .host_end(host_end), .irq(irq), .dma_done(dma_done),
      .byte_count(byte_count), .addr_count(addr_count)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic sub);
      @(negedge clk); host_rd = 1'b1; host_is_sub = sub;
      @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic load(input logic [15:0] c, input logic [15:0] a);
      wr(3'd1, c[7:0]); wr(3'd2, c[15:8]); wr(3'd3, a[7:0]); wr(3'd4, a[15:8]);
   endtask

   typedef struct packed {
      logic [2:0]  dst;
      logic        sub;
      logic [15:0] cnt;
      logic [15:0] adr;
      logic [15:0] exp_adr;
      logic [15:0] exp_cnt;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{3'd2, 1'b0, 16'h0100, 16'h0010, 16'h0012, 16'h00FE},
      '{3'd2, 1'b1, 16'h0100, 16'h0010, 16'h0010, 16'h0100},
      '{3'd3, 1'b1, 16'h0FFF, 16'h3FFF, 16'h4001, 16'h0FFD},
      '{3'd3, 1'b0, 16'h0040, 16'h1235, 16'h1235, 16'h0040},
      '{3'd2, 1'b0, 16'h0020, 16'hC000, 16'hC002, 16'h001E},
      '{3'd3, 1'b1, 16'h0003, 16'h0100, 16'h0102, 16'h0001}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 idle", 16'(xfer_idle), 16'd1);
      chk("R1 unav", 16'(data_avail_n), 16'd1);
      chk("R1 endp", 16'(end_pend_n), 16'd1);
      chk("R1 flags", {12'd0, host_ready, host_end, irq, dma_done}, 16'd0);
      chk("R1 cnt", byte_count, 16'h0000);
      chk("R1 adr", addr_count, 16'h0000);

      // R4 vector walk: read data and counter advance per CPU identity
      for (int i = 0; i < 6; i++) begin
         wr(3'd6, 8'h00);
         wr(3'd0, 8'h01);
         load(VECS[i].cnt, VECS[i].adr);
         dest_code = VECS[i].dst;
         wr(3'd5, 8'h00);
         rd(VECS[i].sub);
         chk("R4 data", host_rdata, ram_word({VECS[i].adr[13:1], 1'b0}));
         chk("R4 adr", addr_count, VECS[i].exp_adr);
         chk("R4 cnt", byte_count, VECS[i].exp_cnt);
      end
      // R6 last vector left one byte: pre-end stage
      chk("R6 endp after vector", 16'(end_pend_n), 16'd0);

      // Full host transfer with interrupt enabled
      wr(3'd6, 8'h00);
      wr(3'd0, 8'h03);
      load(16'h0005, 16'h0200);
      dest_code = 3'd2;
      wr(3'd5, 8'h00);
      // R3 host trigger flags
      chk("R3 idle", 16'(xfer_idle), 16'd0);
      chk("R3 unav", 16'(data_avail_n), 16'd0);
      chk("R3 ready/end", {14'd0, host_ready, host_end}, 16'b10);
      rd(1'b0);
      chk("R6 no early pre-end", {14'd0, end_pend_n, irq}, 16'b10);
      rd(1'b0);
      // R6 pre-end stage
      chk("R6 cnt", byte_count, 16'h0001);
      chk("R6 endp/irq", {14'd0, end_pend_n, irq}, 16'b01);
      chk("R6 ready/end", {14'd0, host_ready, host_end}, 16'b11);
      rd(1'b0);
      // R5 completion
      chk("R5 cnt", byte_count, 16'hFFFF);
      chk("R5 adr", addr_count, 16'h0206);
      chk("R5 flags", {12'd0, xfer_idle, data_avail_n, host_ready, host_end}, 16'b1101);
      rd(1'b0);
      // R7 read while unavailable
      chk("R7 data", host_rdata, 16'hFFFF);
      chk("R7 cnt", byte_count, 16'hFFFF);
      chk("R7 adr", addr_count, 16'h0206);
      wr(3'd6, 8'h00);
      // R8 acknowledge
      chk("R8 endp", 16'(end_pend_n), 16'd1);
      chk("R8 irq", 16'(irq), 16'd0);
      chk("R8 cnt", byte_count, 16'h0FFF);

      // R2 trigger ignored with output enable clear
      wr(3'd0, 8'h02);
      wr(3'd5, 8'h00);
      chk("R2 oe-off idle", 16'(xfer_idle), 16'd1);
      chk("R2 oe-off unav", 16'(data_avail_n), 16'd1);
      // R2 invalid code
      wr(3'd0, 8'h01);
      load(16'h0001, 16'h0300);
      dest_code = 3'd1;
      wr(3'd5, 8'h00);
      chk("R2 inv idle", 16'(xfer_idle), 16'd0);
      chk("R2 inv unav", 16'(data_avail_n), 16'd1);
      k = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (dma_done) k++;
      end
      chk("R2 inv no done", 16'(k), 16'd0);

      // R9 abort
      load(16'h0020, 16'h0400);
      dest_code = 3'd3;
      wr(3'd5, 8'h00);
      chk("R9 started", 16'(data_avail_n), 16'd0);
      wr(3'd0, 8'h00);
      chk("R9 idle/unav", {14'd0, xfer_idle, data_avail_n}, 16'b11);
      rd(1'b1);
      chk("R9 read after abort", host_rdata, 16'hFFFF);
      chk("R9 cnt kept", byte_count, 16'h0020);

      // R10 DMA completion timing
      wr(3'd0, 8'h03);
      load(16'h0010, 16'h0400);
      dest_code = 3'd4;
      wr(3'd5, 8'h00);
      k = 0;
      while (!dma_done && k < 1000) begin
         @(negedge clk);
         k++;
      end
      chk("R10 delay", 16'(k), 16'd65);
      chk("R10 adr", addr_count, 16'h0411);
      chk("R10 cnt", byte_count, 16'hFFFF);
      chk("R10 flags", {11'd0, xfer_idle, data_avail_n, host_end, end_pend_n, irq}, 16'b11101);
      @(negedge clk);
      chk("R10 pulse width", 16'(dma_done), 16'd0);
      // R8 acknowledge with decoder pending keeps irq
      dec_irq_pend = 1'b1;
      wr(3'd6, 8'h00);
      chk("R8 dec keeps irq", {14'd0, end_pend_n, irq}, 16'b11);
      dec_irq_pend = 1'b0;
      wr(3'd6, 8'h00);
      chk("R8 irq drop", 16'(irq), 16'd0);
      // R3 trigger masks reloaded count; R10 zero-length DMA
      dest_code = 3'd2;
      wr(3'd0, 8'h01);
      wr(3'd5, 8'h00);
      chk("R3 mask", byte_count, 16'h0FFF);
      load(16'h0000, 16'h0500);
      dest_code = 3'd7;
      wr(3'd5, 8'h00);
      k = 0;
      while (!dma_done && k < 1000) begin
         @(negedge clk);
         k++;
      end
      chk("R10 zero delay", 16'(k), 16'd1);
      chk("R10 zero adr", addr_count, 16'h0501);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule